// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block steers a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) around its hazards. Each cycle it looks at the instruction class and register numbers held in the decode, execute, memory and writeback stage registers. It also sees the write-enable and load flags of the later stages and the branch condition computed in execute. From these it produces:

- an operand source select for each of the two ALU inputs;
- a stall that freezes fetch and decode;
- a no-op bubble for the execute register;
- a kill for the wrong-path fetch;
- the fetch address.

Results leave the ALU and go straight back to a dependent instruction without waiting for writeback. A loaded value cannot be ready for the very next instruction, so that case costs exactly one bubble. Branches resolve in execute, where a dedicated target adder works beside the PC+4 adder of fetch. The instruction that follows a branch is a delay slot and always completes. Filling the slot is left to the software's instruction ordering.

The block owns the fetch PC register. The surrounding datapath applies the selects to its operand multiplexers. It zeroes the execute register while `ex_bubble` is high and turns the fetched word into a no-op while `fetch_squash` is high. The register file is assumed to write before it reads within a cycle.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When the instruction in memory writes a non-zero register `mem_rd`, is not a load, and `mem_rd` equals a source the execute instruction reads, that operand select is 2'b10 (memory-stage result).
- R2: When no such memory-stage match exists and writeback writes a non-zero `wb_rd` equal to a read source, the select is 2'b01 (writeback result); otherwise it is 2'b00 (register file).
- R3: When both memory and writeback match the same source, the memory-stage result wins (2'b10).
- R4: A load sitting in the memory stage (`mem_mem_rd`=1) is never a forwarding source, since its data is not yet available.
- R5: Register 0 is never forwarded and never causes a stall.
- R6: Class encoding is 0 no-op, 1 ALU, 2 load, 3 store, 4 branch. The first source is read by ALU, load, store and branch. The second source is read by ALU, store and branch. Forwarding and stalls consider only the sources that are read.
- R7: When execute holds a load (`ex_reg_wr`=1, `ex_mem_rd`=1) whose destination equals a source that the decode instruction reads, `stall` and `ex_bubble` are both 1 for that cycle. In all other cases both are 0.
- R8: In a stall cycle, `fetch_pc` keeps its value at the next clock edge.
- R9: When execute holds a branch (class 4) with `br_taken`=1 and there is no stall, `pc_sel` and `fetch_squash` are 1. The next `fetch_pc` is then `ex_pc` plus the sign-extended `br_disp` times 4.
- R10: With neither a stall nor a taken branch, `fetch_pc` advances by 4 modulo 2^XLEN.
- R11: A taken branch never stalls or bubbles the delay-slot instruction in decode; only the fetch behind it is killed.
- R12: Synchronous reset loads `fetch_pc` with RESET_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_class | input | 3 | Class of decode-stage instruction |
| id_rs1 | input | REG_AW | Decode first source |
| id_rs2 | input | REG_AW | Decode second source |
| ex_class | input | 3 | Class of execute-stage instruction |
| ex_rs1 | input | REG_AW | Execute first source |
| ex_rs2 | input | REG_AW | Execute second source |
| ex_rd | input | REG_AW | Execute destination |
| ex_reg_wr | input | 1 | Execute instruction writes a register |
| ex_mem_rd | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Memory-stage destination |
| mem_reg_wr | input | 1 | Memory-stage instruction writes a register |
| mem_mem_rd | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_AW | Writeback destination |
| wb_reg_wr | input | 1 | Writeback instruction writes a register |
| br_taken | input | 1 | Branch condition outcome from execute |
| ex_pc | input | XLEN | Address of execute instruction |
| br_disp | input | DISP_W | Signed branch displacement in instructions |
| fwd_a | output | 2 | First ALU operand source select |
| fwd_b | output | 2 | Second ALU operand source select |
| stall | output | 1 | Freeze PC and decode register |
| ex_bubble | output | 1 | Load a no-op into execute |
| fetch_squash | output | 1 | Kill the instruction fetched behind the delay slot |
| pc_sel | output | 1 | 1: next PC is branch target, 0: PC+4 |
| fetch_pc | output | XLEN | Current fetch address |

## Verification
The bench builds the block with XLEN=16, DISP_W=8 and RESET_PC=16'hFFF0. With these values the sequential PC wraps through zero within four fetches, and negative displacements produce targets that wrap below zero. The random phase draws register numbers only from 0 to 3, so matches between stages, double matches between memory and writeback, and register-0 cases occur in most cycles. Every class, including the load flag in memory, is mixed in on each cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [2:0] {
        CLS_NOP    = 3'd0,
        CLS_ALU    = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_BRANCH = 3'd4
    } icls_e;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } opsrc_e;

    localparam int N_SRC = 2;

    // first source: everything except the no-op reads it
    function automatic logic reads_src_a(icls_e c);
        return (c == CLS_ALU) || (c == CLS_LOAD) || (c == CLS_STORE) || (c == CLS_BRANCH);
    endfunction

    // second source: loads take only a base register
    function automatic logic reads_src_b(icls_e c);
        return (c == CLS_ALU) || (c == CLS_STORE) || (c == CLS_BRANCH);
    endfunction

endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              used,
    input  logic [REG_AW-1:0] rs,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_ok,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_ok,
    output opsrc_e            sel
);
    logic live;
    assign live = used && (rs != '0);

    always_comb begin
        sel = SRC_RF;
        if (live) begin
            if (mem_ok && (mem_rd == rs)) begin
                sel = SRC_MEM;       // younger result first
            end else if (wb_ok && (wb_rd == rs)) begin
                sel = SRC_WB;
            end
        end
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  icls_e             id_cls,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_reg_wr,
    input  logic              ex_mem_rd,
    output logic              hit
);
    logic [REG_AW-1:0] src [N_SRC];
    logic [N_SRC-1:0]  used;
    logic [N_SRC-1:0]  src_hit;
    logic              load_live;

    assign src[0]  = id_rs1;
    assign src[1]  = id_rs2;
    assign used[0] = reads_src_a(id_cls);
    assign used[1] = reads_src_b(id_cls);

    assign load_live = ex_reg_wr && ex_mem_rd && (ex_rd != '0);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign src_hit[g] = used[g] && (src[g] == ex_rd);
    end

    assign hit = load_live && (|src_hit);
endmodule

// File: rtl/hz_pc_unit.sv
module hz_pc_unit #(
    parameter int                XLEN     = 32,
    parameter int                DISP_W   = 16,
    parameter logic [XLEN-1:0]   RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              take,
    input  logic [XLEN-1:0]   ex_pc,
    input  logic [DISP_W-1:0] disp,
    output logic [XLEN-1:0]   pc
);
    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] disp_ext;
    logic [XLEN-1:0] tgt_pc;
    logic [XLEN-1:0] pc_d;

    // fetch-side incrementer
    assign seq_pc   = pc_q + XLEN'(4);
    // execute-side target adder, displacement counted in words
    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    assign tgt_pc   = ex_pc + (disp_ext << 2);

    always_comb begin
        if (hold)      pc_d = pc_q;
        else if (take) pc_d = tgt_pc;
        else           pc_d = seq_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= pc_d;
    end

    assign pc = pc_q;
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import hz_pkg::*;
#(
    parameter int              REG_AW   = 5,
    parameter int              XLEN     = 32,
    parameter int              DISP_W   = 16,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        id_class,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic [2:0]        ex_class,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_reg_wr,
    input  logic              ex_mem_rd,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_reg_wr,
    input  logic              mem_mem_rd,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_reg_wr,
    input  logic              br_taken,
    input  logic [XLEN-1:0]   ex_pc,
    input  logic [DISP_W-1:0] br_disp,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              stall,
    output logic              ex_bubble,
    output logic              fetch_squash,
    output logic              pc_sel,
    output logic [XLEN-1:0]   fetch_pc
);
    icls_e id_cls;
    icls_e ex_cls;
    assign id_cls = icls_e'(id_class);
    assign ex_cls = icls_e'(ex_class);

    // ---------------- operand forwarding ----------------
    logic [REG_AW-1:0] ex_src [N_SRC];
    logic [N_SRC-1:0]  ex_use;
    opsrc_e            fsel   [N_SRC];
    logic              mem_ok;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;
    assign ex_use[0] = reads_src_a(ex_cls);
    assign ex_use[1] = reads_src_b(ex_cls);
    // a load in memory only has its address, not its data
    assign mem_ok    = mem_reg_wr && !mem_mem_rd;

    for (genvar g = 0; g < N_SRC; g++) begin : g_fwd
        hz_fwd_sel #(.REG_AW(REG_AW)) u_sel (
            .used   (ex_use[g]),
            .rs     (ex_src[g]),
            .mem_rd (mem_rd),
            .mem_ok (mem_ok),
            .wb_rd  (wb_rd),
            .wb_ok  (wb_reg_wr),
            .sel    (fsel[g])
        );
    end

    assign fwd_a = fsel[0];
    assign fwd_b = fsel[1];

    // ---------------- load-use interlock ----------------
    logic lu_hit;

    hz_load_use #(.REG_AW(REG_AW)) u_lu (
        .id_cls    (id_cls),
        .id_rs1    (id_rs1),
        .id_rs2    (id_rs2),
        .ex_rd     (ex_rd),
        .ex_reg_wr (ex_reg_wr),
        .ex_mem_rd (ex_mem_rd),
        .hit       (lu_hit)
    );

    assign stall     = lu_hit;
    assign ex_bubble = lu_hit;

    // ---------------- branch and fetch address ----------------
    logic br_go;
    assign br_go        = (ex_cls == CLS_BRANCH) && br_taken && !lu_hit;
    assign pc_sel       = br_go;
    // the delay slot in decode is left alone; the fetch behind it dies
    assign fetch_squash = br_go;

    hz_pc_unit #(
        .XLEN     (XLEN),
        .DISP_W   (DISP_W),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk   (clk),
        .rst   (rst),
        .hold  (lu_hit),
        .take  (br_go),
        .ex_pc (ex_pc),
        .disp  (br_disp),
        .pc    (fetch_pc)
    );
endmodule

// File: rtl/hz_chk.sv
module hz_chk #(
    parameter int REG_AW = 5,
    parameter int XLEN   = 32,
    parameter int DISP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [REG_AW-1:0] ex_rs1,
    input logic              ex_mem_rd,
    input logic              mem_mem_rd,
    input logic [XLEN-1:0]   ex_pc,
    input logic [DISP_W-1:0] br_disp,
    input logic [1:0]        fwd_a,
    input logic [1:0]        fwd_b,
    input logic              stall,
    input logic              ex_bubble,
    input logic              fetch_squash,
    input logic              pc_sel,
    input logic [XLEN-1:0]   fetch_pc
);
    logic [XLEN-1:0] want_tgt;
    assign want_tgt = ex_pc + (XLEN'($signed(br_disp)) << 2);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> fetch_pc == $past(fetch_pc));

    // R9
    branch_target_chk: assert property (@(posedge clk) disable iff (rst)
        pc_sel |=> fetch_pc == $past(want_tgt));

    // R10
    seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !pc_sel) |=> fetch_pc == $past(fetch_pc) + XLEN'(4));

    // R4
    load_not_forwarded_chk: assert property (@(posedge clk) disable iff (rst)
        mem_mem_rd |-> (fwd_a != 2'b10) && (fwd_b != 2'b10));

    // R5
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_rs1 == '0) |-> fwd_a == 2'b00);

    // R7
    stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> ex_mem_rd && ex_bubble);

    // R11
    slot_kept_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_squash |-> !stall && !ex_bubble && pc_sel);
endmodule

bind pipe_hazard_ctrl hz_chk #(
    .REG_AW (REG_AW),
    .XLEN   (XLEN),
    .DISP_W (DISP_W)
) chk_i (.*);

// File: tb/pipe_hazard_ctrl_tb_top.sv
module pipe_hazard_ctrl_tb_top;
    localparam int              AW   = 5;
    localparam int              XL   = 16;
    localparam int              DW   = 8;
    localparam logic [XL-1:0]   RPC  = 16'hFFF0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    id_class, ex_class;
    logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic          ex_reg_wr, ex_mem_rd, mem_reg_wr, mem_mem_rd, wb_reg_wr, br_taken;
    logic [XL-1:0] ex_pc;
    logic [DW-1:0] br_disp;
    logic [1:0]    fwd_a, fwd_b;
    logic          stall, ex_bubble, fetch_squash, pc_sel;
    logic [XL-1:0] fetch_pc;

    int n_chk = 0;
    int n_err = 0;
    logic [XL-1:0] model_pc;

    always #4 clk = ~clk;   // 8 ns period

    pipe_hazard_ctrl #(.REG_AW(AW), .XLEN(XL), .DISP_W(DW), .RESET_PC(RPC)) dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit rd_a(int c); return c >= 1 && c <= 4; endfunction
    function automatic bit rd_b(int c); return c == 1 || c == 3 || c == 4; endfunction

    function automatic int ref_src(bit used, int rs);
        if (!used || rs == 0) return 0;
        if (mem_reg_wr && !mem_mem_rd && int'(mem_rd) == rs) return 2;
        if (wb_reg_wr && int'(wb_rd) == rs) return 1;
        return 0;
    endfunction

    task automatic idle();
        id_class = 0; ex_class = 0; id_rs1 = 0; id_rs2 = 0;
        ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_reg_wr = 0; ex_mem_rd = 0;
        mem_rd = 0; mem_reg_wr = 0; mem_mem_rd = 0; wb_rd = 0; wb_reg_wr = 0;
        br_taken = 0; ex_pc = 0; br_disp = 0;
    endtask

    // inputs are set at a negedge; compare before the posedge, update model after it
    task automatic step();
        bit es, eb;
        logic [XL-1:0] nxt;
        #2;
        es = ex_reg_wr && ex_mem_rd && ex_rd != 0 &&
             ((rd_a(int'(id_class)) && id_rs1 == ex_rd) || (rd_b(int'(id_class)) && id_rs2 == ex_rd));
        eb = (ex_class == 3'd4) && br_taken && !es;
        chk("R6 fwd_a", fwd_a, ref_src(rd_a(int'(ex_class)), int'(ex_rs1)));
        chk("R6 fwd_b", fwd_b, ref_src(rd_b(int'(ex_class)), int'(ex_rs2)));
        chk("R7 stall", stall, es);
        chk("R7 bubble", ex_bubble, es);
        chk("R9 pc_sel", pc_sel, eb);
        chk("R11 squash", fetch_squash, eb);
        chk("R10 fetch_pc", fetch_pc, model_pc);
        if (es)      nxt = model_pc;
        else if (eb) nxt = ex_pc + (XL'($signed(br_disp)) << 2);
        else         nxt = model_pc + 16'd4;
        @(posedge clk);
        model_pc = nxt;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [XL-1:0] held;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_pc = RPC;
        chk("R12 reset pc", fetch_pc, RPC);

        // R10: four sequential fetches wrap from FFF0 to 0000
        for (int i = 0; i < 4; i++) step();
        chk("R10 wrap", fetch_pc, 16'h0000);

        // R1: ALU result in memory feeds first operand
        idle(); ex_class = 1; ex_rs1 = 3; ex_rs2 = 5; mem_rd = 3; mem_reg_wr = 1;
        #1 chk("R1 mem fwd", fwd_a, 2'b10);
        chk("R1 other operand", fwd_b, 2'b00);
        step();

        // R2: writeback result feeds second operand
        idle(); ex_class = 1; ex_rs2 = 5; wb_rd = 5; wb_reg_wr = 1;
        #1 chk("R2 wb fwd", fwd_b, 2'b01);
        step();

        // R3: both stages match, memory wins
        idle(); ex_class = 3; ex_rs1 = 4; mem_rd = 4; mem_reg_wr = 1; wb_rd = 4; wb_reg_wr = 1;
        #1 chk("R3 priority", fwd_a, 2'b10);
        step();

        // R4: load in memory is skipped, writeback used
        idle(); ex_class = 1; ex_rs1 = 4; mem_rd = 4; mem_reg_wr = 1; mem_mem_rd = 1;
        wb_rd = 4; wb_reg_wr = 1;
        #1 chk("R4 load skipped", fwd_a, 2'b01);
        step();

        // R5: register zero
        idle(); ex_class = 1; ex_rs1 = 0; mem_rd = 0; mem_reg_wr = 1;
        id_class = 1; id_rs1 = 0; ex_rd = 0; ex_reg_wr = 1; ex_mem_rd = 1;
        #1 chk("R5 no fwd r0", fwd_a, 2'b00);
        chk("R5 no stall r0", stall, 1'b0);
        step();

        // R7, R8: load-use on second source
        idle(); ex_class = 2; ex_rd = 6; ex_reg_wr = 1; ex_mem_rd = 1; id_class = 1; id_rs2 = 6;
        held = model_pc;
        #1 chk("R7 stall", stall, 1'b1);
        chk("R7 bubble", ex_bubble, 1'b1);
        step();
        chk("R8 pc held", fetch_pc, held);

        // R6: a load in decode does not read its second field
        idle(); ex_class = 2; ex_rd = 6; ex_reg_wr = 1; ex_mem_rd = 1; id_class = 2; id_rs2 = 6;
        #1 chk("R6 unused src", stall, 1'b0);
        step();

        // R9, R11: taken branch with negative displacement
        idle(); ex_class = 4; br_taken = 1; ex_pc = 16'h0100; br_disp = 8'hFE;
        id_class = 1; id_rs1 = 2;
        #1 chk("R9 pc_sel", pc_sel, 1'b1);
        chk("R11 slot not stalled", stall, 1'b0);
        chk("R11 squash", fetch_squash, 1'b1);
        step();
        chk("R9 target", fetch_pc, 16'h00F8);

        // R10: branch not taken
        idle(); ex_class = 4; br_taken = 0; ex_pc = 16'h0100; br_disp = 8'h10;
        #1 chk("R10 not taken", pc_sel, 1'b0);
        step();
        chk("R10 seq", fetch_pc, 16'h00FC);

        // mixed traffic
        for (int i = 0; i < 800; i++) begin
            int ec, mc;
            idle();
            ec = $urandom_range(0, 4);
            mc = $urandom_range(0, 4);
            id_class   = 3'($urandom_range(0, 4));
            ex_class   = 3'(ec);
            id_rs1     = AW'($urandom_range(0, 3));
            id_rs2     = AW'($urandom_range(0, 3));
            ex_rs1     = AW'($urandom_range(0, 3));
            ex_rs2     = AW'($urandom_range(0, 3));
            ex_rd      = AW'($urandom_range(0, 3));
            ex_reg_wr  = (ec == 1 || ec == 2);
            ex_mem_rd  = (ec == 2);
            mem_rd     = AW'($urandom_range(0, 3));
            mem_reg_wr = (mc == 1 || mc == 2);
            mem_mem_rd = (mc == 2);
            wb_rd      = AW'($urandom_range(0, 3));
            wb_reg_wr  = 1'($urandom_range(0, 1));
            br_taken   = 1'($urandom_range(0, 1));
            ex_pc      = XL'($urandom);
            br_disp    = DW'($urandom);
            step();
        end
        finish_run();
    end
endmodule